// File: doc/BRIEF.md
# Frame Alignment Offset Meter

This block measures how far the falling edge of one chosen frame-evaluation line lags a reference frame pulse. The reference pulse and the clock come from the same timing source. Software picks one of the evaluation lines with a select field and raises a start control. The block then waits for the next reference pulse and counts whole clock cycles until the chosen line falls. It reports that count together with a phase bit, which halves the measurement step by telling whether the edge came while the clock was high or while it was low.

The selected line passes through a short synchroniser before its edge is detected. The delay this adds is taken back out of the count, so the reported offset refers to the cycle in which the edge actually happened. When the start control falls, the result is cleared and a quiet period begins. The start control must then stay low for one whole frame before another rising edge of it is accepted.

Controller states and transitions:
- IDLE → ARM when start rises.
- ARM → MEASURE when the reference pulse is sampled.
- MEASURE → DONE when an edge is found, or when the window runs out.
- ARM, MEASURE or DONE → GAP when start falls.
- GAP → IDLE once start has been low for a full frame.
- In GAP, a high start holds the state in GAP and restarts the frame count.

Top module: `frame_offset_meter`

## Requirements
- R1: After reset, `done_o`, `offset_o` and `phase_o` are all 0.
- R2: Only the line whose index equals `sel_i` is measured. A falling edge on any other line has no effect on the result.
- R3: A rising edge of `start_i` (sampled on rising clock edges) arms the block. Counting then begins at the next rising clock edge that samples `frm_pulse_i` high.
- R4: `offset_o` gives the number of whole clock cycles from the rising edge that sampled the reference pulse to the start of the clock cycle that holds the first falling edge of the selected line. An edge inside the very next cycle reads 0.
- R5: `phase_o` is 1 when the edge came while the clock was high (between a rising and the following falling clock edge). It is 0 when the edge came while the clock was low.
- R6: For an edge in the cycle with offset k, `done_o` goes to 1 right after the rising clock edge k+3 edges after the reference edge. This follows from the SYNC_STAGES=2 synchroniser plus one result register.
- R7: If the selected line does not fall within FRAME_CLKS cycles of the reference edge, `done_o` goes to 1 right after rising edge FRAME_CLKS+3. In that case `offset_o` is all ones (511) and `phase_o` is 0.
- R8: Once the start control drops to 0, the next rising clock edge clears `done_o`, `offset_o` and `phase_o`. This also aborts a measurement in progress, so a later edge produces no result.
- R9: After `start_i` falls, a rising edge of `start_i` is ignored unless `start_i` has first stayed low for FRAME_CLKS consecutive clock cycles.
- R10: While `done_o` is 1 and `start_i` stays 1, `offset_o` and `phase_o` do not change, even when the selected line toggles again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_pulse_i | input | 1 | Reference frame pulse, one cycle high, synchronous to clk |
| fe_i | input | NUM_IN (24) | Frame-evaluation lines |
| sel_i | input | SEL_W (5) | Index of the line to measure |
| start_i | input | 1 | Start control; a rising edge arms, a fall clears |
| done_o | output | 1 | Measurement complete, result valid |
| offset_o | output | CNT_W (9) | Measured offset in whole clock cycles |
| phase_o | output | 1 | 1 = edge during clock high, 0 = during clock low |

## Verification
The main measurement is driven with edges placed in the low phase at offset 6, in the high phase at offset 8, and in the high phase at offset 0. Together these separate an off-by-one in the latency compensation from a swapped phase decision. An edge on a line that is not selected must produce the saturated timeout, which tells a faulty input mux apart from a faulty edge detector. An abort in the middle of a measurement and a re-arm attempted too early both must leave the result empty. A normal measurement after a full quiet frame then confirms that the block recovers.

// File: rtl/fam_pkg.sv
package fam_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ARM,
        S_MEAS,
        S_DONE,
        S_GAP
    } fam_state_t;
endpackage

// File: rtl/fam_cycle_cnt.sv
module fam_cycle_cnt #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    // Saturating up-counter with synchronous clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_o <= '0;
        else if (clr_i)          cnt_o <= '0;
        else if (cnt_o != '1)    cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/fam_sampler.sv
module fam_sampler #(
    parameter int NUM_IN      = 24,
    parameter int SEL_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] fe_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic              fall_o,
    output logic              high_o
);
    logic                   pick;
    logic                   neg_q;
    logic [SYNC_STAGES:0]   p_sh;   // rising-edge samples, index 0 newest
    logic [SYNC_STAGES-1:0] n_sh;   // falling-edge samples paired with p_sh

    // Input mux; an index beyond the last line reads as idle high.
    always_comb begin
        pick = 1'b1;
        for (int i = 0; i < NUM_IN; i++)
            if (sel_i == SEL_W'(i)) pick = fe_i[i];
    end

    // Mid-cycle sample taken at the falling clock edge.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) neg_q <= 1'b1;
        else        neg_q <= pick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_sh <= '1;
            n_sh <= '1;
        end else begin
            p_sh[0] <= pick;
            n_sh[0] <= neg_q;
            for (int s = 1; s <= SYNC_STAGES; s++) p_sh[s] <= p_sh[s-1];
            for (int s = 1; s < SYNC_STAGES; s++)  n_sh[s] <= n_sh[s-1];
        end
    end

    // Fall between two synchronised rising-edge samples; the mid-cycle
    // sample of the later pair tells which clock phase held the edge.
    assign fall_o = p_sh[SYNC_STAGES] & ~p_sh[SYNC_STAGES-1];
    assign high_o = ~n_sh[SYNC_STAGES-1];
endmodule

// File: rtl/fam_ctrl.sv
module fam_ctrl
    import fam_pkg::*;
#(
    parameter int CNT_W      = 9,
    parameter int CYC_W      = 10,
    parameter int GAP_W      = 10,
    parameter int FRAME_CLKS = 512,
    parameter int LAT        = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             frm_i,
    input  logic             fall_i,
    input  logic             high_i,
    input  logic [CYC_W-1:0] cyc_i,
    input  logic [GAP_W-1:0] gap_i,
    output logic             cyc_clr_o,
    output logic             gap_clr_o,
    output logic             done_o,
    output logic [CNT_W-1:0] offset_o,
    output logic             phase_o
);
    localparam logic [CYC_W-1:0] LAT_C   = CYC_W'(LAT);
    localparam logic [CYC_W-1:0] TMO_C   = CYC_W'(FRAME_CLKS + LAT);
    localparam logic [GAP_W-1:0] GAP_END = GAP_W'(FRAME_CLKS - 1);

    fam_state_t state, nxt;
    logic       start_q;
    logic       hit, tmo;

    assign hit       = fall_i && (cyc_i >= LAT_C);
    assign tmo       = (cyc_i >= TMO_C);
    assign cyc_clr_o = (state == S_ARM) && frm_i;
    assign gap_clr_o = start_i || (state != S_GAP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            start_q <= 1'b0;
        end else begin
            state   <= nxt;
            start_q <= start_i;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (start_i && !start_q) nxt = S_ARM;
            S_ARM:  if (!start_i) nxt = S_GAP;
                    else if (frm_i) nxt = S_MEAS;
            S_MEAS: if (!start_i) nxt = S_GAP;
                    else if (hit || tmo) nxt = S_DONE;
            S_DONE: if (!start_i) nxt = S_GAP;
            S_GAP:  if (!start_i && gap_i == GAP_END) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o   <= 1'b0;
            offset_o <= '0;
            phase_o  <= 1'b0;
        end else if (!start_i) begin
            done_o   <= 1'b0;
            offset_o <= '0;
            phase_o  <= 1'b0;
        end else if (state == S_MEAS && tmo) begin
            done_o   <= 1'b1;
            offset_o <= '1;
            phase_o  <= 1'b0;
        end else if (state == S_MEAS && hit) begin
            done_o   <= 1'b1;
            offset_o <= CNT_W'(cyc_i - LAT_C);
            phase_o  <= high_i;
        end
    end

    // R8: a falling start control leaves an empty result
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_i) |=> (!done_o && offset_o == '0 && !phase_o));
    // R10: result frozen while complete and still started
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> (done_o && $stable(offset_o) && $stable(phase_o)));
    // R9: a high start during the quiet frame keeps the block quiet
    p_gap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_GAP && start_i) |=> (state == S_GAP && !done_o));
    // R7: the measuring window never runs past the timeout point
    p_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MEAS) |-> (cyc_i <= TMO_C));
    // R3: measuring only starts from the armed state
    p_arm_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_ARM && state != S_MEAS) |=> (state != S_MEAS));
endmodule

// File: rtl/frame_offset_meter.sv
module frame_offset_meter #(
    parameter int NUM_IN      = 24,
    parameter int SEL_W       = 5,
    parameter int CNT_W       = 9,
    parameter int FRAME_CLKS  = 512,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_pulse_i,
    input  logic [NUM_IN-1:0] fe_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              start_i,
    output logic              done_o,
    output logic [CNT_W-1:0]  offset_o,
    output logic              phase_o
);
    localparam int CYC_W = $clog2(FRAME_CLKS + SYNC_STAGES + 1);
    localparam int GAP_W = $clog2(FRAME_CLKS + 1);

    logic             fall, high;
    logic             cyc_clr, gap_clr;
    logic [CYC_W-1:0] cyc;
    logic [GAP_W-1:0] gap;

    fam_sampler #(.NUM_IN(NUM_IN), .SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)) u_smp (
        .clk(clk), .rst_n(rst_n), .fe_i(fe_i), .sel_i(sel_i),
        .fall_o(fall), .high_o(high)
    );

    fam_cycle_cnt #(.W(CYC_W)) u_cyc (
        .clk(clk), .rst_n(rst_n), .clr_i(cyc_clr), .cnt_o(cyc)
    );

    fam_cycle_cnt #(.W(GAP_W)) u_gap (
        .clk(clk), .rst_n(rst_n), .clr_i(gap_clr), .cnt_o(gap)
    );

    fam_ctrl #(
        .CNT_W(CNT_W), .CYC_W(CYC_W), .GAP_W(GAP_W),
        .FRAME_CLKS(FRAME_CLKS), .LAT(SYNC_STAGES)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .frm_i(frm_pulse_i),
        .fall_i(fall), .high_i(high), .cyc_i(cyc), .gap_i(gap),
        .cyc_clr_o(cyc_clr), .gap_clr_o(gap_clr),
        .done_o(done_o), .offset_o(offset_o), .phase_o(phase_o)
    );
endmodule

// File: tb/sim_frame_offset_meter.sv
module sim_frame_offset_meter;
    localparam int CLK_P = 10;
    localparam int Q     = CLK_P / 4;
    localparam int FRAME = 512;
    localparam int LAT   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_pulse = 1'b0;
    logic [23:0] fe = '1;
    logic [4:0]  sel = '0;
    logic        start = 1'b0;
    logic        done;
    logic [8:0]  offset;
    logic        phase;
    int          errors = 0;
    int          total = 0;
    int          fr_cnt = 0;
    bit          finished = 0;

    frame_offset_meter u0 (
        .clk(clk), .rst_n(rst_n), .frm_pulse_i(frm_pulse), .fe_i(fe),
        .sel_i(sel), .start_i(start), .done_o(done), .offset_o(offset), .phase_o(phase)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(negedge clk) begin
        fr_cnt    = (fr_cnt + 1) % FRAME;
        frm_pulse = (fr_cnt == 0);
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse();
        do @(posedge clk); while (!frm_pulse);
    endtask

    // Full quiet frame, arm, place an edge on line drv at offset k.
    task automatic run_meas(input int sel_v, input int drv, input int k, input bit hi,
                            input int exp_off, input bit exp_ph, input int exp_lat,
                            input string tag);
        int n;
        start = 1'b0;
        fe = '1;
        sel = 5'(sel_v);
        repeat (FRAME + 6) @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        wait_pulse();
        repeat (k) @(posedge clk);
        if (hi) #2;
        else begin @(negedge clk); #2; end
        fe[drv] = 1'b0;
        n = k;
        for (int i = 0; i < FRAME + 20; i++) begin
            @(posedge clk); n++; #Q;
            if (done) break;
        end
        check({tag, " latency"}, n, exp_lat);
        check({tag, " offset"}, int'(offset), exp_off);
        check({tag, " phase"}, int'(phase), int'(exp_ph));
        if (drv == sel_v) begin
            // R10: further toggles leave the result alone
            fe[drv] = 1'b1;
            repeat (5) @(posedge clk);
            #Q fe[drv] = 1'b0;
            repeat (10) @(posedge clk);
            #Q;
            check("R10 held offset", int'(offset), exp_off);
            check("R10 held done", int'(done), 1);
        end
        // R8: dropping start clears on the next rising edge
        start = 1'b0;
        @(posedge clk); #Q;
        check("R8 clear done", int'(done), 0);
        check("R8 clear offset", int'(offset), 0);
        check("R8 clear phase", int'(phase), 0);
    endtask

    task automatic t_reset();
        #Q;
        check("R1 reset done", int'(done), 0);
        check("R1 reset offset", int'(offset), 0);
        check("R1 reset phase", int'(phase), 0);
    endtask

    task automatic t_abort();
        start = 1'b0;
        fe = '1;
        sel = 5'd4;
        repeat (FRAME + 6) @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        wait_pulse();
        repeat (3) @(posedge clk);
        #Q start = 1'b0;
        repeat (7) @(posedge clk);
        #Q fe[4] = 1'b0;
        repeat (30) @(posedge clk);
        #Q;
        check("R8 abort done", int'(done), 0);
        check("R8 abort offset", int'(offset), 0);
    endtask

    task automatic t_early_rearm();
        fe = '1;
        sel = 5'd9;
        repeat (50) @(posedge clk);
        #Q start = 1'b1;
        @(posedge clk);
        wait_pulse();
        repeat (5) @(posedge clk);
        #Q fe[9] = 1'b0;
        repeat (FRAME + 20) @(posedge clk);
        #Q;
        check("R9 early rearm ignored", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        // R4 R5 R6 R3: low-phase edge at offset 6
        run_meas(5, 5, 6, 1'b0, 6, 1'b0, 6 + 3, "R4 R5 R6 low k6");
        // R4 R5 R6: high-phase edge at offset 8
        run_meas(23, 23, 8, 1'b1, 8, 1'b1, 8 + 3, "R4 R5 R6 high k8");
        // R4 R5: boundary, edge right after the reference edge
        run_meas(0, 0, 0, 1'b1, 0, 1'b1, 3, "R4 R5 high k0");
        // R2 R7: edge on an unselected line gives the saturated timeout
        run_meas(2, 7, 10, 1'b0, 511, 1'b0, FRAME + LAT + 1, "R2 R7 unselected");
        t_abort();
        t_early_rearm();
        // R9: after a full quiet frame a new measurement works
        run_meas(9, 9, 12, 1'b0, 12, 1'b0, 12 + 3, "R9 R3 recovered");
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            errors++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, total);
            $finish;
        end
    end
endmodule